// File: doc/BRIEF.md
# Bus Access Violation Monitor

This block sits beside the slave port of an on-chip bus and checks every transaction that arrives. For each transaction it raises two flags. The first is an address fault, when the offset lies outside the decoded window. Memory-mapped and MSR accesses have separate windows. The second is a type fault, when the transaction code is not on a fixed list of accepted codes. The monitor observes only the transaction code, the address space flag and the address. It never touches the data path.

Two 64-bit model-specific registers record the faults.

- The interrupt register holds one sticky status bit and one mask bit.
- The error register holds a sticky address-fault bit and a sticky type-fault bit, each with its own mask.

All status bits are cleared by writing 1 to them. A level interrupt output stays high while any unmasked status is pending. Software can remove it by clearing the status or by setting the interrupt mask.

Top module: `bus_viol_mon`

## Requirements
- R1: After reset both registers read as 64'h0 and `smi_irq` is low.
- R2: A memory-mapped transaction (`txn_is_msr`=0) with address above 7Fh sets the interrupt status and the address-fault status. An address of exactly 7Fh sets neither.
- R3: An MSR transaction (`txn_is_msr`=1) with address above 2000_0007h sets the interrupt status and the address-fault status. An address of exactly 2000_0007h sets neither.
- R4: Type codes 0 (null), 1 (non-coherent read), 2 (non-coherent write), 3 (non-coherent read, bus exclusive), 4 (MSR read), 5 (MSR write) and 6 (bus exclusive) are legal. Any other 4-bit code sets the interrupt status and the type-fault status.
- R5: The interrupt register is at MSR address A000_2002h. Bit 32 is its status and bit 0 is its mask. All other bits read 0.
- R6: Writing 1 to bit 32 of the interrupt register clears its status. Writing 0 there leaves the status unchanged.
- R7: While the interrupt mask is set, violations do not set the interrupt status and `smi_irq` stays low.
- R8: Once raised, `smi_irq` stays high until every pending unmasked status is cleared or the interrupt mask is set.
- R9: The error register is at MSR address A000_2003h. Its bits are:
  - bit 0: type-fault mask
  - bit 1: address-fault mask
  - bit 32: type-fault status
  - bit 33: address-fault status

  The status bits clear when 1 is written to them. Other bits read 0.
- R10: A violation whose error mask bit is set leaves that error status bit clear.
- R11: A pending unmasked error status drives `smi_irq` only while the interrupt mask is clear.
- R12: When a violation and a write-one-to-clear of the same status bit arrive in the same cycle, the status bit stays set.
- R13: Address and type inputs have no effect while `txn_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_valid | input | 1 | One-cycle strobe marking a transaction |
| txn_type | input | 4 | Transaction type code |
| txn_is_msr | input | 1 | 1 = MSR access, 0 = memory-mapped access |
| txn_addr | input | 32 | Transaction address |
| cfg_wr | input | 1 | MSR write strobe |
| cfg_rd | input | 1 | MSR read enable (combinational read data) |
| cfg_addr | input | 32 | MSR address for read or write |
| cfg_wdata | input | 64 | MSR write data |
| cfg_rdata | output | 64 | MSR read data, zero when unselected |
| smi_irq | output | 1 | Level interrupt request |

## Verification
The bound checker tests several rules on every clock cycle:
- the address windows of both spaces set status on the next cycle;
- an illegal code sets the type fault;
- a status bit holds unless a 1 is written to it;
- an active interrupt mask keeps the output low;
- a violation beats a concurrent clear;
- nothing changes when both strobes are idle.

Other behaviour can only be shown by the bench's scenarios. These cover the register bit layouts seen through reads, the exact boundary addresses, and the interaction between the two registers. In particular, an error status keeps the output high after the interrupt status is cleared, and the output reasserts when the mask is lifted.

// File: rtl/bvm_pkg.sv
package bvm_pkg;
   localparam int SMI_STAT_BIT = 32;
   localparam int SMI_MASK_BIT = 0;
   localparam int ERR_TMASK_BIT = 0;
   localparam int ERR_AMASK_BIT = 1;
   localparam int ERR_TSTAT_BIT = 32;
   localparam int ERR_ASTAT_BIT = 33;
   localparam int NUM_ERR = 2;
   localparam int ERR_IDX_TYPE = 0;
   localparam int ERR_IDX_ADDR = 1;

   typedef struct packed {
      logic addr_bad;
      logic type_bad;
   } viol_t;
endpackage

// File: rtl/bvm_classifier.sv
module bvm_classifier
   import bvm_pkg::*;
#(
   parameter int TYPE_W = 4,
   parameter int ADDR_W = 32,
   parameter logic [ADDR_W-1:0] MEM_LIMIT = 'h7F,
   parameter logic [ADDR_W-1:0] MSR_LIMIT = 'h2000_0007,
   parameter logic [(2**TYPE_W)-1:0] LEGAL_TYPES = 'h7F
) (
   input  logic              txn_valid,
   input  logic [TYPE_W-1:0] txn_type,
   input  logic              txn_is_msr,
   input  logic [ADDR_W-1:0] txn_addr,
   output viol_t             viol
);
   localparam int NTYPES = 2 ** TYPE_W;

   logic [ADDR_W-1:0] limit_sel;
   logic              over_limit;
   logic [NTYPES-1:0] type_hot;

   always_comb begin
      limit_sel  = txn_is_msr ? MSR_LIMIT : MEM_LIMIT;
      over_limit = txn_addr > limit_sel;
   end

   for (genvar gi = 0; gi < NTYPES; gi++) begin : g_tdec
      assign type_hot[gi] = (txn_type == TYPE_W'(gi));
   end

   always_comb begin
      viol.addr_bad = txn_valid && over_limit;
      viol.type_bad = txn_valid && ((type_hot & LEGAL_TYPES) == '0);
   end
endmodule

// File: rtl/bvm_sticky.sv
module bvm_sticky #(
   parameter int N = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   for (genvar gi = 0; gi < N; gi++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if (set[gi])
            bit_q <= 1'b1;
         else if (clr[gi])
            bit_q <= 1'b0;
      end
      assign q[gi] = bit_q;
   end
endmodule

// File: rtl/bvm_regs.sv
module bvm_regs
   import bvm_pkg::*;
#(
   parameter int MSR_AW = 32,
   parameter int DATA_W = 64,
   parameter logic [MSR_AW-1:0] SMI_ADDR = 'hA000_2002,
   parameter logic [MSR_AW-1:0] ERR_ADDR = 'hA000_2003
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr,
   input  logic               cfg_rd,
   input  logic [MSR_AW-1:0]  cfg_addr,
   input  logic [DATA_W-1:0]  cfg_wdata,
   output logic [DATA_W-1:0]  cfg_rdata,
   input  logic               smi_stat,
   input  logic [NUM_ERR-1:0] err_stat,
   output logic               smi_mask,
   output logic [NUM_ERR-1:0] err_mask,
   output logic               smi_clr,
   output logic [NUM_ERR-1:0] err_clr
);
   logic hit_smi, hit_err;
   logic wr_smi, wr_err;
   logic smi_mask_q;
   logic [NUM_ERR-1:0] err_mask_q;
   logic [DATA_W-1:0] smi_view, err_view;

   assign hit_smi = (cfg_addr == SMI_ADDR);
   assign hit_err = (cfg_addr == ERR_ADDR);
   assign wr_smi  = cfg_wr && hit_smi;
   assign wr_err  = cfg_wr && hit_err;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smi_mask_q <= 1'b0;
         err_mask_q <= '0;
      end else begin
         if (wr_smi)
            smi_mask_q <= cfg_wdata[SMI_MASK_BIT];
         if (wr_err) begin
            err_mask_q[ERR_IDX_TYPE] <= cfg_wdata[ERR_TMASK_BIT];
            err_mask_q[ERR_IDX_ADDR] <= cfg_wdata[ERR_AMASK_BIT];
         end
      end
   end

   assign smi_mask = smi_mask_q;
   assign err_mask = err_mask_q;
   assign smi_clr  = wr_smi && cfg_wdata[SMI_STAT_BIT];
   assign err_clr[ERR_IDX_TYPE] = wr_err && cfg_wdata[ERR_TSTAT_BIT];
   assign err_clr[ERR_IDX_ADDR] = wr_err && cfg_wdata[ERR_ASTAT_BIT];

   always_comb begin
      smi_view = '0;
      smi_view[SMI_STAT_BIT] = smi_stat;
      smi_view[SMI_MASK_BIT] = smi_mask_q;
      err_view = '0;
      err_view[ERR_TSTAT_BIT] = err_stat[ERR_IDX_TYPE];
      err_view[ERR_ASTAT_BIT] = err_stat[ERR_IDX_ADDR];
      err_view[ERR_TMASK_BIT] = err_mask_q[ERR_IDX_TYPE];
      err_view[ERR_AMASK_BIT] = err_mask_q[ERR_IDX_ADDR];
      if (!cfg_rd)
         cfg_rdata = '0;
      else if (hit_smi)
         cfg_rdata = smi_view;
      else if (hit_err)
         cfg_rdata = err_view;
      else
         cfg_rdata = '0;
   end
endmodule

// File: rtl/bvm_irq.sv
module bvm_irq
   import bvm_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smi_stat,
   input  logic               smi_mask,
   input  logic [NUM_ERR-1:0] err_stat,
   input  logic [NUM_ERR-1:0] err_mask,
   output logic               irq
);
   logic pend;
   assign pend = !smi_mask && (smi_stat || ((err_stat & ~err_mask) != '0));

   if (IRQ_REG) begin : g_flop
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            irq_q <= 1'b0;
         else
            irq_q <= pend;
      end
      assign irq = irq_q;
   end else begin : g_comb
      assign irq = pend;
   end
endmodule

// File: rtl/bus_viol_mon.sv
module bus_viol_mon
   import bvm_pkg::*;
#(
   parameter int TYPE_W = 4,
   parameter int ADDR_W = 32,
   parameter int MSR_AW = 32,
   parameter int DATA_W = 64,
   parameter logic [ADDR_W-1:0] MEM_LIMIT = 'h7F,
   parameter logic [ADDR_W-1:0] MSR_LIMIT = 'h2000_0007,
   parameter logic [(2**TYPE_W)-1:0] LEGAL_TYPES = 'h7F,
   parameter logic [MSR_AW-1:0] SMI_ADDR = 'hA000_2002,
   parameter logic [MSR_AW-1:0] ERR_ADDR = 'hA000_2003,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              txn_valid,
   input  logic [TYPE_W-1:0] txn_type,
   input  logic              txn_is_msr,
   input  logic [ADDR_W-1:0] txn_addr,
   input  logic              cfg_wr,
   input  logic              cfg_rd,
   input  logic [MSR_AW-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic              smi_irq
);
   if (DATA_W < ERR_ASTAT_BIT + 1) begin : g_bad_dw
      $error("DATA_W too small for status bit layout");
   end
   if (TYPE_W < 3 || TYPE_W > 8) begin : g_bad_tw
      $error("TYPE_W out of supported range");
   end
   if (SMI_ADDR == ERR_ADDR) begin : g_bad_map
      $error("register addresses must differ");
   end

   viol_t viol;
   logic               smi_stat_q, smi_mask_q, smi_clr, smi_set;
   logic [NUM_ERR-1:0] err_stat_q, err_mask_q, err_clr, err_set;

   bvm_classifier #(
      .TYPE_W(TYPE_W), .ADDR_W(ADDR_W), .MEM_LIMIT(MEM_LIMIT),
      .MSR_LIMIT(MSR_LIMIT), .LEGAL_TYPES(LEGAL_TYPES)
   ) u_cls (
      .txn_valid(txn_valid), .txn_type(txn_type), .txn_is_msr(txn_is_msr),
      .txn_addr(txn_addr), .viol(viol)
   );

   assign smi_set = (viol.addr_bad || viol.type_bad) && !smi_mask_q;
   assign err_set[ERR_IDX_TYPE] = viol.type_bad && !err_mask_q[ERR_IDX_TYPE];
   assign err_set[ERR_IDX_ADDR] = viol.addr_bad && !err_mask_q[ERR_IDX_ADDR];

   bvm_sticky #(.N(1)) u_smi_st (
      .clk(clk), .rst_n(rst_n), .set(smi_set), .clr(smi_clr), .q(smi_stat_q)
   );

   bvm_sticky #(.N(NUM_ERR)) u_err_st (
      .clk(clk), .rst_n(rst_n), .set(err_set), .clr(err_clr), .q(err_stat_q)
   );

   bvm_regs #(
      .MSR_AW(MSR_AW), .DATA_W(DATA_W), .SMI_ADDR(SMI_ADDR), .ERR_ADDR(ERR_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .smi_stat(smi_stat_q), .err_stat(err_stat_q),
      .smi_mask(smi_mask_q), .err_mask(err_mask_q),
      .smi_clr(smi_clr), .err_clr(err_clr)
   );

   bvm_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .smi_stat(smi_stat_q), .smi_mask(smi_mask_q),
      .err_stat(err_stat_q), .err_mask(err_mask_q), .irq(smi_irq)
   );
endmodule

// File: rtl/bvm_checker.sv
module bvm_checker #(
   parameter int TYPE_W = 4,
   parameter int ADDR_W = 32,
   parameter int MSR_AW = 32,
   parameter int DATA_W = 64,
   parameter logic [ADDR_W-1:0] MEM_LIMIT = 'h7F,
   parameter logic [ADDR_W-1:0] MSR_LIMIT = 'h2000_0007,
   parameter logic [(2**TYPE_W)-1:0] LEGAL_TYPES = 'h7F,
   parameter logic [MSR_AW-1:0] SMI_ADDR = 'hA000_2002
) (
   input logic              clk,
   input logic              rst_n,
   input logic              txn_valid,
   input logic [TYPE_W-1:0] txn_type,
   input logic              txn_is_msr,
   input logic [ADDR_W-1:0] txn_addr,
   input logic              cfg_wr,
   input logic [MSR_AW-1:0] cfg_addr,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic              smi_irq,
   input logic              smi_stat,
   input logic              smi_mask,
   input logic [1:0]        err_stat,
   input logic [1:0]        err_mask
);
   logic smi_w1c, any_bad;
   assign smi_w1c = cfg_wr && (cfg_addr == SMI_ADDR) && cfg_wdata[32];
   assign any_bad = txn_valid && (!LEGAL_TYPES[txn_type] ||
                    (txn_is_msr ? (txn_addr > MSR_LIMIT) : (txn_addr > MEM_LIMIT)));

   p_mem_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid && !txn_is_msr && (txn_addr > MEM_LIMIT) && !smi_mask && !err_mask[1]
      |=> smi_stat && err_stat[1]);

   p_msr_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid && txn_is_msr && (txn_addr > MSR_LIMIT) && !smi_mask && !err_mask[1]
      |=> smi_stat && err_stat[1]);

   p_bad_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid && !LEGAL_TYPES[txn_type] && !err_mask[0] |=> err_stat[0]);

   p_w1c_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      smi_stat && !smi_w1c |=> smi_stat);

   p_mask_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      smi_mask && $past(smi_mask) |-> !smi_irq);

   p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      smi_stat && !smi_mask && $past(smi_stat && !smi_mask) |-> smi_irq);

   p_tmask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_mask[0] && !err_stat[0] && !cfg_wr |=> !err_stat[0]);

   p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      any_bad && !smi_mask && smi_w1c |=> smi_stat);

   p_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !txn_valid && !cfg_wr |=> $stable({smi_stat, smi_mask, err_stat, err_mask}));
endmodule

bind bus_viol_mon bvm_checker #(
   .TYPE_W(TYPE_W), .ADDR_W(ADDR_W), .MSR_AW(MSR_AW), .DATA_W(DATA_W),
   .MEM_LIMIT(MEM_LIMIT), .MSR_LIMIT(MSR_LIMIT), .LEGAL_TYPES(LEGAL_TYPES),
   .SMI_ADDR(SMI_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_type(txn_type),
   .txn_is_msr(txn_is_msr), .txn_addr(txn_addr), .cfg_wr(cfg_wr),
   .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .smi_irq(smi_irq),
   .smi_stat(smi_stat_q), .smi_mask(smi_mask_q),
   .err_stat(err_stat_q), .err_mask(err_mask_q)
);

// File: tb/bus_viol_mon_bench.sv
module bus_viol_mon_bench;
   localparam logic [31:0] A_SMI = 32'hA000_2002;
   localparam logic [31:0] A_ERR = 32'hA000_2003;
   localparam logic [63:0] W_CLR_SMI = 64'h0000_0001_0000_0000;
   localparam logic [63:0] W_CLR_ERR = 64'h0000_0003_0000_0000;
   localparam int NV = 10;
   // {is_msr, type[3:0], addr[31:0], exp_smi, exp_addr_err, exp_type_err}
   localparam logic [39:0] VEC [NV] = '{
      {1'b0, 4'd1, 32'h0000_007F, 3'b000},   // R2 boundary
      {1'b0, 4'd1, 32'h0000_0080, 3'b110},   // R2
      {1'b1, 4'd4, 32'h2000_0007, 3'b000},   // R3 boundary
      {1'b1, 4'd5, 32'h2000_0008, 3'b110},   // R3
      {1'b0, 4'd7, 32'h0000_0010, 3'b101},   // R4 first illegal code
      {1'b0, 4'd0, 32'h0000_0010, 3'b000},   // R4 null
      {1'b0, 4'd15, 32'h0000_0200, 3'b111},  // R4 + R2
      {1'b1, 4'd6, 32'h0000_0000, 3'b000},   // R4 bus exclusive
      {1'b0, 4'd3, 32'h0000_0000, 3'b000},   // R4
      {1'b1, 4'd2, 32'hA000_2002, 3'b110}    // R3
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic txn_valid = 1'b0;
   logic [3:0] txn_type = '0;
   logic txn_is_msr = 1'b0;
   logic [31:0] txn_addr = '0;
   logic cfg_wr = 1'b0;
   logic cfg_rd = 1'b0;
   logic [31:0] cfg_addr = '0;
   logic [63:0] cfg_wdata = '0;
   logic [63:0] cfg_rdata;
   logic smi_irq;
   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bus_viol_mon u_bus_viol_mon (
      .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_type(txn_type),
      .txn_is_msr(txn_is_msr), .txn_addr(txn_addr), .cfg_wr(cfg_wr),
      .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .smi_irq(smi_irq)
   );

   task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic txn(logic msr, logic [3:0] ty, logic [31:0] a);
      @(negedge clk);
      txn_valid = 1'b1; txn_is_msr = msr; txn_type = ty; txn_addr = a;
      @(negedge clk);
      txn_valid = 1'b0;
   endtask

   task automatic wr(logic [31:0] a, logic [63:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd(logic [31:0] a, output logic [63:0] d);
      @(negedge clk);
      cfg_rd = 1'b1; cfg_addr = a;
      #1 d = cfg_rdata;
      cfg_rd = 1'b0;
   endtask

   task automatic clear_all();
      wr(A_SMI, W_CLR_SMI);
      wr(A_ERR, W_CLR_ERR);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [63:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state, R5 and R9 reserved bits zero
      rd(A_SMI, d); chk("R1 smi reg after reset", d, 64'h0);
      rd(A_ERR, d); chk("R1 err reg after reset", d, 64'h0);
      chk("R1 irq after reset", {63'h0, smi_irq}, 64'h0);

      // Vector table walk: R2 R3 R4
      for (int i = 0; i < NV; i++) begin
         logic [39:0] v;
         v = VEC[i];
         clear_all();
         txn(v[39], v[38:35], v[34:3]);
         chk("R2/R3/R4 irq", {63'h0, smi_irq}, {63'h0, v[2]});
         rd(A_SMI, d); chk("R2/R3/R4 R5 smi status", d, {31'h0, v[2], 32'h0});
         rd(A_ERR, d); chk("R2/R3/R4 R9 err status", d, {30'h0, v[1], v[0], 32'h0});
      end
      clear_all();

      // R13: invalid strobe ignored
      @(negedge clk);
      txn_is_msr = 1'b0; txn_type = 4'd15; txn_addr = 32'hFFFF_FFFF;
      repeat (2) @(negedge clk);
      txn_type = 4'd0; txn_addr = 32'h0;
      rd(A_SMI, d); chk("R13 smi untouched", d, 64'h0);
      rd(A_ERR, d); chk("R13 err untouched", d, 64'h0);
      chk("R13 irq low", {63'h0, smi_irq}, 64'h0);

      // R6, R8, R11: write-zero keeps, write-one clears, error keeps irq
      txn(1'b0, 4'd1, 32'h100);
      wr(A_SMI, 64'h0);
      rd(A_SMI, d); chk("R6 write 0 keeps status", d, W_CLR_SMI);
      repeat (5) @(negedge clk);
      chk("R8 irq held", {63'h0, smi_irq}, 64'h1);
      wr(A_SMI, W_CLR_SMI);
      rd(A_SMI, d); chk("R6 write 1 clears status", d, 64'h0);
      chk("R11 error status keeps irq", {63'h0, smi_irq}, 64'h1);
      wr(A_ERR, W_CLR_ERR);
      chk("R8 irq drops after all cleared", {63'h0, smi_irq}, 64'h0);

      // R7 / R11: interrupt mask
      wr(A_SMI, 64'h1);
      txn(1'b0, 4'd9, 32'h10);
      rd(A_SMI, d); chk("R7 masked smi status stays clear", d, 64'h1);
      chk("R7 irq low while masked", {63'h0, smi_irq}, 64'h0);
      rd(A_ERR, d); chk("R11 err records under smi mask", d, 64'h0000_0001_0000_0000);
      wr(A_SMI, 64'h0);
      chk("R11 irq rises when mask lifted", {63'h0, smi_irq}, 64'h1);
      wr(A_ERR, W_CLR_ERR);
      chk("R11 irq low after err clear", {63'h0, smi_irq}, 64'h0);

      // R8: masking drops a pending irq
      txn(1'b0, 4'd1, 32'h300);
      wr(A_SMI, 64'h1);
      chk("R8 mask drops irq", {63'h0, smi_irq}, 64'h0);
      wr(A_SMI, W_CLR_SMI);
      wr(A_ERR, W_CLR_ERR);

      // R10: error masks
      wr(A_ERR, 64'h3);
      txn(1'b0, 4'd12, 32'h400);
      rd(A_ERR, d); chk("R10 masked errors stay clear", d, 64'h3);
      rd(A_SMI, d); chk("R10 smi still records", d, W_CLR_SMI);
      wr(A_SMI, W_CLR_SMI);
      chk("R10 masked error gives no irq", {63'h0, smi_irq}, 64'h0);

      // R9 / R5 layout with all-ones writes
      wr(A_ERR, 64'h0);
      txn(1'b0, 4'd8, 32'h500);
      wr(A_ERR, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(A_ERR, d); chk("R9 all-ones write: masks set, status cleared", d, 64'h3);
      wr(A_SMI, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(A_SMI, d); chk("R5 all-ones write: mask only", d, 64'h1);
      wr(A_SMI, 64'h0);
      wr(A_ERR, 64'h0);

      // R12: violation beats simultaneous clear
      txn(1'b1, 4'd4, 32'h3000_0000);
      @(negedge clk);
      txn_valid = 1'b1; txn_is_msr = 1'b1; txn_type = 4'd4; txn_addr = 32'h3000_0000;
      cfg_wr = 1'b1; cfg_addr = A_SMI; cfg_wdata = W_CLR_SMI;
      @(negedge clk);
      txn_valid = 1'b0; cfg_wr = 1'b0;
      rd(A_SMI, d); chk("R12 set wins over clear", d, W_CLR_SMI);
      clear_all();
      rd(A_SMI, d); chk("R12 later clear works", d, 64'h0);

      finish_run();
   end
endmodule